// File: doc/BRIEF.md
# Subtractive GCD Engine

This block finds the greatest common divisor of two unsigned operands by repeated subtraction. It has two parts. A controller state machine steps through a fixed table of numbered states. A datapath holds two working registers and a result register, and the controller drives it only through per-register select and load strobes. The datapath reports back through comparison flags.

A user holds `opa_i` and `opb_i` steady and raises `start_i` for at least two cycles. The engine latches the first operand and then, one cycle later, the second. It then subtracts the smaller working value from the larger until the two are equal, or until one of them is zero. At that point it writes the result to `result_o` and pulses `result_vld_o` for one cycle. The result stays on `result_o` until the next computation finishes or a reset clears it.

Top module: `gcd_engine`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low at a rising edge, `result_o` becomes 0, `result_vld_o` becomes 0 and the controller returns to its boot state. A computation cut short by reset produces no result pulse.
- R2: `start_i` is sampled only in the polling state. Because the idle loop alternates between a polling state and its join state, `start_i` must stay high for two cycles to be seen. A start pulse during a computation neither restarts it nor changes its result.
- R3: The first working register is loaded from `opa_i` in the cycle after start is accepted, and the second from `opb_i` in the cycle after that. Later operand changes do not affect the running computation.
- R4: While the working values differ and both are nonzero, the smaller value is subtracted from the larger. The second register is reduced when the first is smaller; otherwise the first register is reduced. The result is the greatest common divisor.
- R5: If one operand is zero, the result is the other operand. If both are zero, the result is 0, and the engine finishes with no subtraction.
- R6: Each subtraction costs 5 cycles. With k subtractions, `result_vld_o` rises at the (5k+4)-th rising edge after the edge that accepts start. It is high for exactly one cycle.
- R7: `result_o` changes only together with a `result_vld_o` pulse, or on reset.
- R8: The controller uses 13 states, coded 0 to 12 on 4 bits. These include join states after the branch, after the inner loop, after the idle test and after the result. The state register never holds codes 13 to 15.
- R9: With W=8 and operands 42 and 8, the engine performs 8 subtractions and the result is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, hold for two cycles |
| opa_i | input | W | First operand |
| opb_i | input | W | Second operand |
| result_o | output | W | Registered greatest common divisor |
| result_vld_o | output | 1 | One-cycle pulse when `result_o` is written |

## Verification
The result and its valid pulse are due 5k+4 rising edges after the edge that accepts start, where k is the subtraction count. The bench works out k and the divisor itself for every operand pair. Start is raised at a falling edge, so acceptance falls on the first or the second following rising edge. The bench therefore counts falling edges until the pulse and accepts exactly 5k+5 or 5k+6. The cycle right after the pulse, and a window after a disturbed run, are sampled to confirm that the pulse has dropped and that the result has held.

// File: rtl/gcd_pkg.sv
// Package: shared types for the GCD engine.
// Assumes: 4-bit state codes; the numbering is fixed by the controller table.
package gcd_pkg;

    // Controller states, numbered in table order (join states included)
    typedef enum logic [3:0] {
        ST_BOOT   = 4'd0,
        ST_POLL   = 4'd1,
        ST_POLL_J = 4'd2,
        ST_LOAD_A = 4'd3,
        ST_LOAD_B = 4'd4,
        ST_LOOP   = 4'd5,
        ST_CMP    = 4'd6,
        ST_SUB_B  = 4'd7,
        ST_SUB_A  = 4'd8,
        ST_CMP_J  = 4'd9,
        ST_LOOP_J = 4'd10,
        ST_EMIT   = 4'd11,
        ST_EMIT_J = 4'd12
    } gcd_state_t;

    // Strobes from the controller to the datapath
    typedef struct packed {
        logic a_pick;   // 0: operand input, 1: a - b
        logic a_load;
        logic b_pick;   // 0: operand input, 1: b - a
        logic b_load;
        logic r_pick;   // 0: a, 1: b
        logic r_load;
    } gcd_ctrl_t;

    // Status flags from the datapath to the controller
    typedef struct packed {
        logic differ;
        logic a_below;
        logic a_zero;
        logic b_zero;
    } gcd_flags_t;

endpackage

// File: rtl/gcd_load_reg.sv
// Module: W-bit register with load enable and synchronous active-low clear.
// Assumes: the clear takes priority over the load.
module gcd_load_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Hold the value, replace it on load, clear it on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (ld)
            q <= d;
    end

endmodule

// File: rtl/gcd_datapath.sv
// Module: GCD datapath with two working registers, two subtractors,
// the comparators and the result register with its valid flag.
// Assumes: the controller asserts a subtract strobe only when the
// subtrahend is the smaller value, so no subtraction wraps.
module gcd_datapath
    import gcd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  gcd_ctrl_t    ctrl,
    output gcd_flags_t   flags,
    output logic [W-1:0] a_val,
    output logic [W-1:0] b_val,
    output logic [W-1:0] result,
    output logic         result_vld
);

    logic [W-1:0] a_diff;
    logic [W-1:0] b_diff;
    logic [W-1:0] a_next;
    logic [W-1:0] b_next;
    logic [W-1:0] r_next;

    // Subtractors: one per working register
    always_comb begin
        a_diff = a_val - b_val;
        b_diff = b_val - a_val;
    end

    // Input selects of the working registers and the result register
    always_comb begin
        a_next = ctrl.a_pick ? a_diff : opa;
        b_next = ctrl.b_pick ? b_diff : opb;
        r_next = ctrl.r_pick ? b_val  : a_val;
    end

    // Comparators feeding the controller
    always_comb begin
        flags.differ  = (a_val != b_val);
        flags.a_below = (a_val <  b_val);
        flags.a_zero  = (a_val == '0);
        flags.b_zero  = (b_val == '0);
    end

    gcd_load_reg #(.W(W)) u_reg_a (
        .clk (clk), .rst_n (rst_n), .ld (ctrl.a_load), .d (a_next), .q (a_val)
    );

    gcd_load_reg #(.W(W)) u_reg_b (
        .clk (clk), .rst_n (rst_n), .ld (ctrl.b_load), .d (b_next), .q (b_val)
    );

    gcd_load_reg #(.W(W)) u_reg_r (
        .clk (clk), .rst_n (rst_n), .ld (ctrl.r_load), .d (r_next), .q (result)
    );

    // Valid flag: high in the cycle after the result is written
    always_ff @(posedge clk) begin
        if (!rst_n)
            result_vld <= 1'b0;
        else
            result_vld <= ctrl.r_load;
    end

endmodule

// File: rtl/gcd_controller.sv
// Module: GCD controller that walks a fixed 13-state table and turns
// each state into datapath strobes.
// Assumes: the flags describe the working registers as they are in the
// current cycle; a zero operand ends the loop at once.
module gcd_controller
    import gcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  gcd_flags_t flags,
    output gcd_ctrl_t  ctrl,
    output gcd_state_t state_q
);

    gcd_state_t state_d;
    logic       loop_exit;

    // Loop ends on equality or when either value is zero
    always_comb begin
        loop_exit = !flags.differ || flags.a_zero || flags.b_zero;
    end

    // Next-state table
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_BOOT:   state_d = ST_POLL;
            ST_POLL:   state_d = start ? ST_LOAD_A : ST_POLL_J;
            ST_POLL_J: state_d = ST_POLL;
            ST_LOAD_A: state_d = ST_LOAD_B;
            ST_LOAD_B: state_d = ST_LOOP;
            ST_LOOP:   state_d = loop_exit ? ST_EMIT : ST_CMP;
            ST_CMP:    state_d = flags.a_below ? ST_SUB_B : ST_SUB_A;
            ST_SUB_B:  state_d = ST_CMP_J;
            ST_SUB_A:  state_d = ST_CMP_J;
            ST_CMP_J:  state_d = ST_LOOP_J;
            ST_LOOP_J: state_d = ST_LOOP;
            ST_EMIT:   state_d = ST_EMIT_J;
            ST_EMIT_J: state_d = ST_BOOT;
            default:   state_d = ST_BOOT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_BOOT;
        else
            state_q <= state_d;
    end

    // Strobes issued in each state
    always_comb begin
        ctrl = '0;
        case (state_q)
            ST_LOAD_A: ctrl.a_load = 1'b1;
            ST_LOAD_B: ctrl.b_load = 1'b1;
            ST_SUB_B: begin
                ctrl.b_pick = 1'b1;
                ctrl.b_load = 1'b1;
            end
            ST_SUB_A: begin
                ctrl.a_pick = 1'b1;
                ctrl.a_load = 1'b1;
            end
            ST_EMIT: begin
                ctrl.r_pick = flags.a_zero;
                ctrl.r_load = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/gcd_engine.sv
// Module: top of the subtractive GCD engine, joining the controller and
// the datapath.
// Assumes: the operands are held from the start request until the second
// working register has been loaded.
module gcd_engine
    import gcd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic [W-1:0] result_o,
    output logic         result_vld_o
);

    gcd_ctrl_t    ctrl;
    gcd_flags_t   flags;
    gcd_state_t   state_q;
    logic [W-1:0] a_val;
    logic [W-1:0] b_val;

    gcd_controller u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .flags   (flags),
        .ctrl    (ctrl),
        .state_q (state_q)
    );

    gcd_datapath #(.W(W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .opa        (opa_i),
        .opb        (opb_i),
        .ctrl       (ctrl),
        .flags      (flags),
        .a_val      (a_val),
        .b_val      (b_val),
        .result     (result_o),
        .result_vld (result_vld_o)
    );

endmodule

// File: rtl/gcd_engine_chk.sv
// Module: property checker bound to the GCD engine.
// Assumes: it sees the engine's state register and working registers.
module gcd_engine_chk
    import gcd_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] result_o,
    input logic         result_vld_o,
    input gcd_state_t   state,
    input logic [W-1:0] a_q,
    input logic [W-1:0] b_q
);

    // R1: a reset edge leaves the outputs cleared and the controller at boot
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && !result_vld_o && state == ST_BOOT));

    // R2: a load of the first register is preceded by the polling state
    assert_start_only_polled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_POLL) |=> (state != ST_LOAD_A));

    // R4: the second register is reduced only by a smaller, nonzero first value
    assert_sub_b_ordered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUB_B) |-> (a_q < b_q && a_q != '0));

    // R4: the first register is reduced only by a smaller, nonzero second value
    assert_sub_a_ordered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUB_A) |-> (b_q < a_q && b_q != '0));

    // R5: the loop leaves only on equality or a zero value
    assert_emit_condition_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT) |-> (a_q == b_q || a_q == '0 || b_q == '0));

    // R6: the valid pulse lasts one cycle
    assert_vld_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld_o |=> !result_vld_o);

    // R7: the result holds unless a valid pulse accompanies it
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !result_vld_o |-> $stable(result_o));

    // R8: the state register stays within the 13 table codes
    assert_state_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state <= ST_EMIT_J);

endmodule

bind gcd_engine gcd_engine_chk #(.W(W)) u_gcd_engine_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .result_o     (result_o),
    .result_vld_o (result_vld_o),
    .state        (state_q),
    .a_q          (a_val),
    .b_q          (b_val)
);

// File: tb/test_gcd_engine.sv
// Bench: exhaustive sweep of a 4-bit engine plus directed cases on an 8-bit one.
module test_gcd_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       n_start = 1'b0;
    logic [3:0] n_a = '0;
    logic [3:0] n_b = '0;
    logic [3:0] n_res;
    logic       n_vld;
    logic       w_start = 1'b0;
    logic [7:0] w_a = '0;
    logic [7:0] w_b = '0;
    logic [7:0] w_res;
    logic       w_vld;

    int total = 0;
    int bad = 0;
    int ticks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    gcd_engine #(.W(4)) i_gcd_engine (
        .clk (clk), .rst_n (rst_n), .start_i (n_start),
        .opa_i (n_a), .opb_i (n_b), .result_o (n_res), .result_vld_o (n_vld)
    );

    gcd_engine #(.W(8)) i_gcd_engine_wide (
        .clk (clk), .rst_n (rst_n), .start_i (w_start),
        .opa_i (w_a), .opb_i (w_b), .result_o (w_res), .result_vld_o (w_vld)
    );

    // Watchdog: an expired run counts as a failure and still reports
    always @(posedge clk) begin
        ticks++;
        if (ticks > 150000 && !finished) begin
            finished = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<=%0d", ticks, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_gcd(input int a, input int b);
        int x = a;
        int y = b;
        while (y != 0) begin
            int t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int ref_steps(input int a, input int b);
        int x = a;
        int y = b;
        int k = 0;
        if (x == 0 || y == 0) return 0;
        while (x != y) begin
            if (x < y) y = y - x;
            else       x = x - y;
            k++;
        end
        return k;
    endfunction

    // Runs one computation; disturb changes operands and pulses start mid-run
    task automatic run_case(input bit wide, input int a, input int b,
                            input bit disturb, input string req);
        int exp_g = ref_gcd(a, b);
        int k = ref_steps(a, b);
        int cyc = 0;
        bit got = 1'b0;
        int res;
        if (wide) begin w_a = a[7:0]; w_b = b[7:0]; w_start = 1'b1; end
        else      begin n_a = a[3:0]; n_b = b[3:0]; n_start = 1'b1; end
        while (!got && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 2) begin w_start = 1'b0; n_start = 1'b0; end
            if (disturb && cyc == 12) begin
                if (wide) begin w_a = ~a[7:0]; w_b = ~b[7:0]; w_start = 1'b1; end
                else      begin n_a = ~a[3:0]; n_b = ~b[3:0]; n_start = 1'b1; end
            end
            if (disturb && cyc == 14) begin w_start = 1'b0; n_start = 1'b0; end
            got = wide ? w_vld : n_vld;
        end
        res = wide ? int'(w_res) : int'(n_res);
        check(got, "R6 pulse seen", int'(got), 1);
        check(res == exp_g, req, res, exp_g);
        // R6/R8: five-cycle loop body, acceptance on the first or second edge
        check(cyc == 5*k + 5 || cyc == 5*k + 6, "R6 latency", cyc, 5*k + 5);
        @(negedge clk);
        check((wide ? w_vld : n_vld) == 1'b0, "R6 one-cycle pulse", 1, 0);
        check((wide ? int'(w_res) : int'(n_res)) == exp_g, "R7 result held",
              wide ? int'(w_res) : int'(n_res), exp_g);
        if (disturb) begin
            bit extra = 1'b0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (wide ? w_vld : n_vld) extra = 1'b1;
            end
            check(!extra, "R2 start ignored mid-run", int'(extra), 0);
            check((wide ? int'(w_res) : int'(n_res)) == exp_g, "R7 result held after wait",
                  wide ? int'(w_res) : int'(n_res), exp_g);
        end
    endtask

    initial begin
        // R1: outputs are cleared while reset is held
        repeat (3) @(negedge clk);
        check(n_res == 4'd0 && w_res == 8'd0, "R1 reset result", int'(n_res) + int'(w_res), 0);
        check(!n_vld && !w_vld, "R1 reset valid", int'(n_vld) + int'(w_vld), 0);
        rst_n = 1'b1;

        // R4 and R5: every 4-bit operand pair
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                run_case(1'b0, a, b, 1'b0, (a == 0 || b == 0) ? "R5 zero operand" : "R4 gcd");
            end
        end

        // R9: 42 and 8 take 8 subtractions and give 2
        check(ref_steps(42, 8) == 8, "R9 reference steps", ref_steps(42, 8), 8);
        run_case(1'b1, 42, 8, 1'b0, "R9 result");
        run_case(1'b1, 255, 1, 1'b0, "R4 long run");
        run_case(1'b1, 200, 75, 1'b0, "R4 gcd wide");
        run_case(1'b1, 17, 255, 1'b0, "R4 gcd wide swapped");
        run_case(1'b1, 0, 0, 1'b0, "R5 both zero");
        run_case(1'b1, 0, 144, 1'b0, "R5 first zero");
        run_case(1'b1, 255, 255, 1'b0, "R4 equal operands");

        // R2 and R3: operand changes and a start pulse during a run are ignored
        run_case(1'b0, 15, 1, 1'b1, "R3 operands latched");
        run_case(1'b1, 250, 6, 1'b1, "R3 operands latched wide");

        // R1: reset in the middle of a run clears the result and drops the run
        n_a = 4'd15; n_b = 4'd2; n_start = 1'b1;
        repeat (2) @(negedge clk);
        n_start = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(n_res == 4'd0, "R1 mid-run reset result", int'(n_res), 0);
        rst_n = 1'b1;
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 120; i++) begin
                @(negedge clk);
                if (n_vld) seen = 1'b1;
            end
            check(!seen, "R1 aborted run silent", int'(seen), 0);
        end
        run_case(1'b0, 12, 9, 1'b0, "R1 recovery after reset");

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule